// File: doc/BRIEF.md
# Embedded Clock False-Lock Detector

The detector watches a one-bit serial stream and finds the bit position that carries the embedded clock. The stream arrives at one bit per clock cycle. Each frame is 12 bits long: a high start bit at offset 0, data bits d0 to d9 at offsets 1 to 10, and a low stop bit at offset 11. The embedded clock shows up as a low-to-high step from the stop bit into the next start bit. That step appears at the same frame position in every frame.

A free-running position counter marks each of the 12 frame phases. Every phase has its own counter of consecutive frames that showed a rising step at that phase. A phase qualifies once its counter saturates. Lock is declared only when a single phase qualifies. A repetitive data word can produce a second recurring rising step. When that happens, the block raises a possible-false-lock flag and keeps lock off until the data changes. After lock, the block watches the locked phase and falls back to searching if the clock step goes missing for several frames in a row.

Top module: `fld_lock_detect`

## Requirements
- R1: A rising step is a 0 in one cycle followed by a 1 in the next. Its phase is the position counter value (0 to 11, free-running from reset) in the cycle that samples the 1. While locked, `phase_o` reports that phase and holds steady. With frames aligned so the start bit falls at position k, the block locks at phase k.
- R2: Each phase counts consecutive frames that showed a rising step at that phase. The count saturates at 16, and a phase qualifies at 16. One frame without the step resets the count to 0, so 16 fresh consecutive frames are needed again.
- R3: The decision is made in the cycle where the position is 11. If exactly one phase qualifies while searching, `lock_o` rises after that edge and `phase_o` gives the qualifying phase. From reset with aligned clean frames, lock is still off after 16 frames and on after 17.
- R4: While searching, two or more qualifying phases set `false_lock_o` and keep `lock_o` low for as long as the pattern persists.
- R5: Once the repetitive pattern changes so that only one phase still qualifies, the next decision clears `false_lock_o` and asserts lock on the surviving phase.
- R6: While locked, if any phase other than the locked one qualifies, lock drops and `false_lock_o` rises at that decision.
- R7: While locked, four consecutive frames without a rising step at the locked phase drop lock and clear all phase counters. Three misses followed by a hit keep lock and restart the miss count.
- R8: A data word with only d9 low adds no candidate, because d9 is followed by the low stop bit. A data word with d8 low and d9 high does add a candidate at phase 10.
- R9: Synchronous reset clears the position, all counters, `lock_o`, `false_lock_o` and `phase_o` to 0.
- R10: `lock_o` and `false_lock_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received serial bit, one per cycle |
| lock_o | output | 1 | Single clock phase found and tracked |
| false_lock_o | output | 1 | More than one recurring rising step seen |
| phase_o | output | 4 | Frame phase of the clock step while locked |

## Verification
The assertions assume that `bit_in` carries one new bit per clock and is settled before each rising edge. They also assume the stream is framed so that the clock step recurs at a single position. The bench drives each bit at the falling edge and builds every frame from a start bit, ten data bits and a stop bit. It inserts all-zero frames wherever a test needs missing clock steps, or needs the clock and data candidates to start counting together. Expected decision times follow from counting frames since reset or since the last missed step. Every check is sampled at a falling edge after a whole frame has been sent.

// File: rtl/fld_pkg.sv
package fld_pkg;

    // Search/track state of the lock controller.
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } fld_state_e;

endpackage

// File: rtl/fld_phase_tracker.sv
// Per-phase run counter of consecutive frames showing a rising step.
module fld_phase_tracker #(
    parameter int QUAL_FRAMES = 16,
    parameter int PHASE       = 0,
    parameter int PW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pos,
    input  logic          edge_seen,
    input  logic          clear,
    output logic          qual_next
);
    localparam int            CW      = $clog2(QUAL_FRAMES + 1);
    localparam logic [CW-1:0] QUAL_V  = CW'(QUAL_FRAMES);
    localparam logic [PW-1:0] PHASE_V = PW'(PHASE);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t st_d, st_q;
    logic eval;

    always_comb begin
        st_d = st_q;
        eval = (pos == PHASE_V);
        if (clear) begin
            st_d.cnt = '0;
        end else if (eval) begin
            if (edge_seen) begin
                if (st_q.cnt != QUAL_V) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end else begin
                st_d.cnt = '0;
            end
        end
        qual_next = (st_d.cnt == QUAL_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a frame missing the step at this phase restarts the run
    assert_miss_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        (eval && !edge_seen) |=> (st_q.cnt == '0));

    // R2: the run counter never passes the qualification count
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= QUAL_V);

endmodule

// File: rtl/fld_candidate_vote.sv
// Counts qualifying phases and picks the lowest one.
module fld_candidate_vote #(
    parameter int N    = 12,
    parameter int PW   = 4,
    parameter int CNTW = 4
) (
    input  logic [N-1:0]    qual_vec,
    output logic [CNTW-1:0] n_qual,
    output logic [PW-1:0]   first_idx
);
    always_comb begin
        n_qual    = '0;
        first_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual_vec[i]) begin
                n_qual    = n_qual + CNTW'(1);
                first_idx = PW'(i);
            end
        end
    end

endmodule

// File: rtl/fld_lock_ctrl.sv
// Position counter, rising-step detection and the search/lock decision.
module fld_lock_ctrl
    import fld_pkg::*;
#(
    parameter int FRAME_LEN   = 12,
    parameter int MISS_FRAMES = 4,
    parameter int PW          = 4,
    parameter int CNTW        = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_in,
    input  logic [CNTW-1:0] n_qual,
    input  logic [PW-1:0]   first_idx,
    output logic [PW-1:0]   pos,
    output logic            edge_seen,
    output logic            clear_all,
    output logic            locked,
    output logic            false_flag,
    output logic [PW-1:0]   phase
);
    localparam int            MW     = $clog2(MISS_FRAMES + 1);
    localparam logic [PW-1:0] LAST   = PW'(FRAME_LEN - 1);
    localparam logic [MW-1:0] MISS_L = MW'(MISS_FRAMES - 1);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic          prev;
        fld_state_e    st;
        logic [PW-1:0] phase;
        logic [MW-1:0] miss;
        logic          fl;
    } ctl_t;

    ctl_t st_d, st_q;
    logic frame_end;
    logic at_lock;
    logic miss_drop;

    always_comb begin
        st_d      = st_q;
        clear_all = 1'b0;
        miss_drop = 1'b0;
        edge_seen = !st_q.prev && bit_in;
        frame_end = (st_q.pos == LAST);
        at_lock   = (st_q.st == ST_LOCKED) && (st_q.pos == st_q.phase);

        st_d.prev = bit_in;
        st_d.pos  = frame_end ? '0 : st_q.pos + PW'(1);

        if (at_lock) begin
            if (edge_seen) begin
                st_d.miss = '0;
            end else if (st_q.miss == MISS_L) begin
                miss_drop = 1'b1;
            end else begin
                st_d.miss = st_q.miss + MW'(1);
            end
        end

        if (miss_drop) begin
            st_d.st   = ST_SEARCH;
            st_d.miss = '0;
            st_d.fl   = 1'b0;
            clear_all = 1'b1;
        end else if (frame_end) begin
            case (st_q.st)
                ST_SEARCH: begin
                    if (n_qual == CNTW'(1)) begin
                        st_d.st    = ST_LOCKED;
                        st_d.phase = first_idx;
                        st_d.miss  = '0;
                        st_d.fl    = 1'b0;
                    end else if (n_qual >= CNTW'(2)) begin
                        st_d.fl = 1'b1;
                    end else begin
                        st_d.fl = 1'b0;
                    end
                end
                ST_LOCKED: begin
                    if (n_qual != '0) begin
                        st_d.st   = ST_SEARCH;
                        st_d.fl   = 1'b1;
                        st_d.miss = '0;
                    end
                end
                default: st_d.st = ST_SEARCH;
            endcase
        end

        pos        = st_q.pos;
        locked     = (st_q.st == ST_LOCKED);
        false_flag = st_q.fl;
        phase      = st_q.phase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.prev <= 1'b1;
            st_q.st   <= ST_SEARCH;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: lock and the false-lock flag exclude each other
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(locked && false_flag));

    // R3: lock only rises after a frame-end decision with one candidate
    assert_lock_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(frame_end && (n_qual == CNTW'(1))));

    // R4: the false-lock flag only rises when several phases qualify
    assert_false_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(false_flag) |-> $past(frame_end && (n_qual != '0)));

    // R7: the last allowed miss at the locked phase drops lock
    assert_miss_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (at_lock && !edge_seen && (st_q.miss == MISS_L)) |=> !locked);

    // R1: the reported phase holds while lock stays on
    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked)) |-> $stable(phase));

    // R1: the position counter stays inside the frame
    assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);

endmodule

// File: rtl/fld_lock_detect.sv
// Top: per-phase trackers, candidate vote and lock controller.
module fld_lock_detect #(
    parameter int FRAME_LEN   = 12,
    parameter int QUAL_FRAMES = 16,
    parameter int MISS_FRAMES = 4,
    parameter int PW          = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_in,
    output logic          lock_o,
    output logic          false_lock_o,
    output logic [PW-1:0] phase_o
);
    localparam int CNTW = $clog2(FRAME_LEN + 1);

    logic [PW-1:0]        pos;
    logic                 edge_seen;
    logic                 clear_all;
    logic                 locked;
    logic                 false_flag;
    logic [PW-1:0]        phase;
    logic [FRAME_LEN-1:0] qual_next;
    logic [FRAME_LEN-1:0] qual_masked;
    logic [CNTW-1:0]      n_qual;
    logic [PW-1:0]        first_idx;

    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_trk
        fld_phase_tracker #(
            .QUAL_FRAMES(QUAL_FRAMES),
            .PHASE      (g),
            .PW         (PW)
        ) trk_i (
            .clk      (clk),
            .rst      (rst),
            .pos      (pos),
            .edge_seen(edge_seen),
            .clear    (clear_all),
            .qual_next(qual_next[g])
        );
    end

    // While locked only the other phases compete.
    always_comb begin
        for (int i = 0; i < FRAME_LEN; i++) begin
            qual_masked[i] = qual_next[i] && !(locked && (phase == PW'(i)));
        end
    end

    fld_candidate_vote #(
        .N   (FRAME_LEN),
        .PW  (PW),
        .CNTW(CNTW)
    ) vote_i (
        .qual_vec (qual_masked),
        .n_qual   (n_qual),
        .first_idx(first_idx)
    );

    fld_lock_ctrl #(
        .FRAME_LEN  (FRAME_LEN),
        .MISS_FRAMES(MISS_FRAMES),
        .PW         (PW),
        .CNTW       (CNTW)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .n_qual    (n_qual),
        .first_idx (first_idx),
        .pos       (pos),
        .edge_seen (edge_seen),
        .clear_all (clear_all),
        .locked    (locked),
        .false_flag(false_flag),
        .phase     (phase)
    );

    assign lock_o       = locked;
    assign false_lock_o = false_flag;
    assign phase_o      = phase;

    // R1: the reported phase is a real frame position
    assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> (phase_o < PW'(FRAME_LEN)));

endmodule

// File: tb/fld_lock_detect_tb_top.sv
module fld_lock_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_in = 1'b1;
    logic       lock_o;
    logic       false_lock_o;
    logic [3:0] phase_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fld_lock_detect dut_i (
        .clk         (clk),
        .rst         (rst),
        .bit_in      (bit_in),
        .lock_o      (lock_o),
        .false_lock_o(false_lock_o),
        .phase_o     (phase_o)
    );

    // Caller always sits at a falling edge.
    task automatic send_bit(input logic b);
        bit_in = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [9:0] d);
        send_bit(1'b1);
        for (int i = 0; i < 10; i++) send_bit(d[i]);
        send_bit(1'b0);
    endtask

    task automatic send_frames(input logic [9:0] d, input int n);
        for (int f = 0; f < n; f++) send_frame(d);
    endtask

    task automatic send_zero_frames(input int n);
        for (int f = 0; f < n; f++)
            for (int i = 0; i < 12; i++) send_bit(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        bit_in = 1'b1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b0;
    endtask

    task automatic check(input string tag, input logic exp_lock,
                         input logic exp_fl, input logic [3:0] exp_ph,
                         input logic chk_ph);
        n_cmp++;
        if (lock_o !== exp_lock || false_lock_o !== exp_fl ||
            (chk_ph && phase_o !== exp_ph) || (lock_o && false_lock_o)) begin
            n_bad++;
            $display("FAIL %s: lock=%0d false=%0d phase=%0d expected lock=%0d false=%0d phase=%0d",
                     tag, lock_o, false_lock_o, phase_o, exp_lock, exp_fl, exp_ph);
        end
    endtask

    localparam logic [9:0] CLEAN    = 10'h3FF; // only the clock step
    localparam logic [9:0] RMT_PH2  = 10'h3FE; // d0 low, d1 high: step at phase 2
    localparam logic [9:0] MSB_LOW  = 10'h1FF; // only d9 low
    localparam logic [9:0] D8_LOW   = 10'h2FF; // d8 low, d9 high: step at phase 10

    initial begin
        do_reset();
        check("R9 reset state", 1'b0, 1'b0, 4'd0, 1'b1);

        // R3: decision timing from reset with aligned clean frames
        send_frames(CLEAN, 16);
        check("R3 no lock after 16 frames", 1'b0, 1'b0, 4'd0, 1'b0);
        send_frames(CLEAN, 1);
        check("R3 lock after 17 frames", 1'b1, 1'b0, 4'd0, 1'b1);

        // R7: miss tolerance and loss of lock
        send_zero_frames(3);
        check("R7 three misses keep lock", 1'b1, 1'b0, 4'd0, 1'b1);
        send_frames(CLEAN, 1);
        send_zero_frames(3);
        check("R7 hit restarts miss count", 1'b1, 1'b0, 4'd0, 1'b1);
        send_zero_frames(1);
        check("R7 fourth miss drops lock", 1'b0, 1'b0, 4'd0, 1'b0);
        send_frames(CLEAN, 15);
        check("R7 search restarted, 15 frames", 1'b0, 1'b0, 4'd0, 1'b0);
        send_frames(CLEAN, 1);
        check("R7 relock after 16 frames", 1'b1, 1'b0, 4'd0, 1'b1);

        // R2: one missing frame restarts the qualification run
        do_reset();
        send_frames(CLEAN, 10);
        send_zero_frames(1);
        send_frames(CLEAN, 15);
        check("R2 run restarted by miss", 1'b0, 1'b0, 4'd0, 1'b0);
        send_frames(CLEAN, 1);
        check("R2 qualifies after 16 fresh frames", 1'b1, 1'b0, 4'd0, 1'b1);

        // R4 / R5: repetitive multi-transition then pattern change
        do_reset();
        send_zero_frames(1);
        send_frames(RMT_PH2, 15);
        check("R4 below threshold", 1'b0, 1'b0, 4'd0, 1'b0);
        send_frames(RMT_PH2, 1);
        check("R4 two candidates flag false lock", 1'b0, 1'b1, 4'd0, 1'b0);
        send_frames(RMT_PH2, 4);
        check("R4 false lock held while pattern repeats", 1'b0, 1'b1, 4'd0, 1'b0);
        send_frames(CLEAN, 1);
        check("R5 pattern change locks clock phase", 1'b1, 1'b0, 4'd0, 1'b1);

        // R6: new candidate appears while locked
        do_reset();
        send_frames(CLEAN, 17);
        check("R6 locked first", 1'b1, 1'b0, 4'd0, 1'b1);
        send_frames(RMT_PH2, 15);
        check("R6 rival below threshold", 1'b1, 1'b0, 4'd0, 1'b1);
        send_frames(RMT_PH2, 1);
        check("R6 rival qualifies, lock dropped", 1'b0, 1'b1, 4'd0, 1'b0);

        // R8: d9 low forms no candidate, d9 high after low d8 does
        do_reset();
        send_frames(MSB_LOW, 16);
        check("R8 d9 low adds no candidate", 1'b0, 1'b0, 4'd0, 1'b0);
        send_frames(MSB_LOW, 1);
        check("R8 d9 low locks normally", 1'b1, 1'b0, 4'd0, 1'b1);
        do_reset();
        send_zero_frames(1);
        send_frames(D8_LOW, 16);
        check("R8 d8 low d9 high is a candidate", 1'b0, 1'b1, 4'd0, 1'b0);

        // R1: sweep of every frame alignment
        for (int k = 0; k < 12; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) send_bit(1'b1);
            send_frames(CLEAN, 20);
            check($sformatf("R1 alignment %0d", k), 1'b1, 1'b0, 4'(k), 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule